// File: doc/BRIEF.md
# Host-to-Controller Mailbox Doorbell Block

This block sits on the management controller's peripheral bus. It gives firmware a small bank of 32-bit registers and a shared mailbox RAM. A status register holds one interrupt flag for each channel. A control register holds one interrupt enable for each channel. A command register collects doorbell bits. The single level interrupt output is high while any channel has both its flag and its enable set.

Firmware clears flags by writing ones to status and rings doorbells by writing ones to command. So no single store can raise a status flag, and no store can drop a doorbell bit. Flags are raised from the host side through one set strobe per channel. The mailbox RAM has its own word-wide port with byte enables, and it reads as zero until a word has been written.

Both ports work as single-cycle request interfaces with no back-pressure. A request is taken in every cycle in which its valid is high. A read answers exactly one cycle later with a response valid pulse. Writes give no response.

Top module: `hbmc_mailbox`

## Requirements
- R1: Status sits at byte offset 0x000, control at 0x004 and command at 0x008. A read request returns the register value one cycle later with `rsp_valid` high, and a write request produces no `rsp_valid`.
- R2: A write to status clears each status bit whose write-data bit is 1 and leaves the other bits as they were.
- R3: A write to control replaces all 32 bits with the write data, and control changes only on such a write.
- R4: A write to command ORs the write data into the register, and no write ever clears a command bit.
- R5: `irq` is high exactly when status AND control is nonzero over channel bits NUM_CH-1:0. Control bits at and above NUM_CH never raise it. It follows every register change by the next cycle.
- R6: A high `host_set[i]` sets status bit i. If a status clear for the same bit arrives in the same cycle, the set wins. Status bits never rise for any other reason.
- R7: A read of an offset that is not one of the three registers returns 0, and a write to such an offset changes nothing. `err` pulses high for one cycle, in the cycle after the access.
- R8: An access whose byte enable is not 4'hF is ignored: a read returns 0 and a write changes nothing. `err` pulses high in the cycle after the access.
- R9: Reset clears status, control and command to zero and holds `irq` low.
- R10: The mailbox RAM holds RAM_BYTES bytes as 32-bit words. A write updates only the bytes whose `ram_be` bit is set (bit b covers data bits 8b+7:8b). A read returns the word one cycle later with `ram_rvalid`. Any word not written since reset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | REG_AW | Byte offset into the register window |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| err | output | 1 | One-cycle pulse after a rejected access |
| host_set | input | NUM_CH | Per-channel status set strobes from the host side |
| irq | output | 1 | Level interrupt |
| ram_valid | input | 1 | Mailbox RAM request |
| ram_write | input | 1 | 1 = write, 0 = read |
| ram_addr | input | RAM_WAW | Word index into the mailbox RAM |
| ram_be | input | 4 | RAM byte enables |
| ram_wdata | input | 32 | RAM write data |
| ram_rvalid | output | 1 | RAM read data valid |
| ram_rdata | output | 32 | RAM read data |

## Verification
The bench builds the block with NUM_CH=8 and REG_AW=12, so it can check that control bit 8 sits just outside the channel mask and that offsets near the top of the 4 KiB window count as unmapped. RAM_BYTES is reduced to 256, which makes the last word (index 63) easy to reach. With this size, words that were never written and words written before a mid-test reset can be read back in a handful of cycles.

// File: rtl/hbmc_mbx_pkg.sv
package hbmc_mbx_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BE_W   = WORD_W / 8;

  localparam logic [11:0] OFF_STATUS  = 12'h000;
  localparam logic [11:0] OFF_CONTROL = 12'h004;
  localparam logic [11:0] OFF_COMMAND = 12'h008;

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_STATUS  = 2'd1,
    SEL_CONTROL = 2'd2,
    SEL_COMMAND = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/hbmc_mbx_regfile.sv
module hbmc_mbx_regfile
  import hbmc_mbx_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned REG_AW = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [REG_AW-1:0]   req_addr,
  input  logic [BE_W-1:0]     req_be,
  input  logic [WORD_W-1:0]   req_wdata,
  input  logic [NUM_CH-1:0]   host_set,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_rdata,
  output logic                err_pulse,
  output logic [NUM_CH-1:0]   status_o,
  output logic [NUM_CH-1:0]   enable_o
);

  localparam logic [BE_W-1:0] BE_FULL = {BE_W{1'b1}};

  logic [NUM_CH-1:0] status_q;
  logic [WORD_W-1:0] control_q;
  logic [WORD_W-1:0] command_q;
  reg_sel_e          sel;
  logic              accept;
  logic              wr_status, wr_control, wr_command;
  logic [NUM_CH-1:0] clr_mask;
  logic [WORD_W-1:0] rd_value;

  always_comb begin
    sel = SEL_NONE;
    if (req_addr == REG_AW'(OFF_STATUS))       sel = SEL_STATUS;
    else if (req_addr == REG_AW'(OFF_CONTROL)) sel = SEL_CONTROL;
    else if (req_addr == REG_AW'(OFF_COMMAND)) sel = SEL_COMMAND;
  end

  assign accept     = req_valid && (req_be == BE_FULL) && (sel != SEL_NONE);
  assign wr_status  = accept && req_write && (sel == SEL_STATUS);
  assign wr_control = accept && req_write && (sel == SEL_CONTROL);
  assign wr_command = accept && req_write && (sel == SEL_COMMAND);
  assign clr_mask   = wr_status ? req_wdata[NUM_CH-1:0] : '0;

  always_comb begin
    rd_value = '0;
    if (accept && !req_write) begin
      unique case (sel)
        SEL_STATUS:  rd_value = WORD_W'(status_q);
        SEL_CONTROL: rd_value = control_q;
        SEL_COMMAND: rd_value = command_q;
        default:     rd_value = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      control_q <= '0;
      command_q <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err_pulse <= 1'b0;
    end else begin
      status_q  <= (status_q & ~clr_mask) | host_set;
      if (wr_control) control_q <= req_wdata;
      if (wr_command) command_q <= command_q | req_wdata;
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= rd_value;
      err_pulse <= req_valid && !accept;
    end
  end

  assign status_o = status_q;
  assign enable_o = control_q[NUM_CH-1:0];

  p_rsp_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  p_status_rise_only_by_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(host_set)) == '0));

  p_host_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_set != '0) |=> ((status_q & $past(host_set)) == $past(host_set)));

  p_control_only_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_write) |-> $stable(control_q));

  p_command_never_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(command_q) & ~command_q) == '0));

  p_err_follows_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req_valid));

endmodule

// File: rtl/hbmc_mbx_irq.sv
module hbmc_mbx_irq #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] status_i,
  input  logic [NUM_CH-1:0] enable_i,
  output logic              irq_o
);

  logic [NUM_CH-1:0] hit;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign hit[ch] = status_i[ch] & enable_i[ch];
  end

  assign irq_o = |hit;

endmodule

// File: rtl/hbmc_mbx_ram.sv
module hbmc_mbx_ram
  import hbmc_mbx_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 16384,
  localparam int unsigned WORDS = RAM_BYTES / BE_W,
  localparam int unsigned WAW   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_valid,
  input  logic              ram_write,
  input  logic [WAW-1:0]    ram_addr,
  input  logic [BE_W-1:0]   ram_be,
  input  logic [WORD_W-1:0] ram_wdata,
  output logic              ram_rvalid,
  output logic [WORD_W-1:0] ram_rdata
);

  logic [WORD_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  written_q;
  logic              do_wr, do_rd;

  assign do_wr = ram_valid && ram_write;
  assign do_rd = ram_valid && !ram_write;

  always_ff @(posedge clk) begin
    if (do_wr) begin
      for (int b = 0; b < int'(BE_W); b++) begin
        if (ram_be[b])
          mem[ram_addr][8*b +: 8] <= ram_wdata[8*b +: 8];
        else if (!written_q[ram_addr])
          mem[ram_addr][8*b +: 8] <= 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written_q  <= '0;
      ram_rvalid <= 1'b0;
      ram_rdata  <= '0;
    end else begin
      if (do_wr) written_q[ram_addr] <= 1'b1;
      ram_rvalid <= do_rd;
      if (do_rd) ram_rdata <= written_q[ram_addr] ? mem[ram_addr] : '0;
    end
  end

  p_ram_rvalid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(do_rd) |-> ram_rvalid);

endmodule

// File: rtl/hbmc_mailbox.sv
module hbmc_mailbox
  import hbmc_mbx_pkg::*;
#(
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned REG_AW    = 12,
  parameter int unsigned RAM_BYTES = 16384,
  localparam int unsigned RAM_WAW  = $clog2(RAM_BYTES / 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [REG_AW-1:0]  req_addr,
  input  logic [3:0]         req_be,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               err,
  input  logic [NUM_CH-1:0]  host_set,
  output logic               irq,
  input  logic               ram_valid,
  input  logic               ram_write,
  input  logic [RAM_WAW-1:0] ram_addr,
  input  logic [3:0]         ram_be,
  input  logic [31:0]        ram_wdata,
  output logic               ram_rvalid,
  output logic [31:0]        ram_rdata
);

  logic [NUM_CH-1:0] status_w;
  logic [NUM_CH-1:0] enable_w;

  hbmc_mbx_regfile #(.NUM_CH(NUM_CH), .REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .host_set  (host_set),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .err_pulse (err),
    .status_o  (status_w),
    .enable_o  (enable_w)
  );

  hbmc_mbx_irq #(.NUM_CH(NUM_CH)) u_irq (
    .status_i (status_w),
    .enable_i (enable_w),
    .irq_o    (irq)
  );

  hbmc_mbx_ram #(.RAM_BYTES(RAM_BYTES)) u_ram (
    .clk        (clk),
    .rst_n      (rst_n),
    .ram_valid  (ram_valid),
    .ram_write  (ram_write),
    .ram_addr   (ram_addr),
    .ram_be     (ram_be),
    .ram_wdata  (ram_wdata),
    .ram_rvalid (ram_rvalid),
    .ram_rdata  (ram_rdata)
  );

  p_irq_needs_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w == '0) |-> !irq);

  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_w == '0) |-> !irq);

endmodule

// File: tb/hbmc_mailbox_tb.sv
module hbmc_mailbox_tb;

  localparam int unsigned NUM_CH    = 8;
  localparam int unsigned REG_AW    = 12;
  localparam int unsigned RAM_BYTES = 256;
  localparam int unsigned RAM_WAW   = $clog2(RAM_BYTES / 4);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0, req_write = 1'b0;
  logic [REG_AW-1:0]  req_addr = '0;
  logic [3:0]         req_be = 4'h0;
  logic [31:0]        req_wdata = '0;
  logic               rsp_valid, err, irq;
  logic [31:0]        rsp_rdata;
  logic [NUM_CH-1:0]  host_set = '0;
  logic               ram_valid = 1'b0, ram_write = 1'b0;
  logic [RAM_WAW-1:0] ram_addr = '0;
  logic [3:0]         ram_be = 4'h0;
  logic [31:0]        ram_wdata = '0;
  logic               ram_rvalid;
  logic [31:0]        ram_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  hbmc_mailbox #(.NUM_CH(NUM_CH), .REG_AW(REG_AW), .RAM_BYTES(RAM_BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err(err),
    .host_set(host_set), .irq(irq),
    .ram_valid(ram_valid), .ram_write(ram_write), .ram_addr(ram_addr),
    .ram_be(ram_be), .ram_wdata(ram_wdata),
    .ram_rvalid(ram_rvalid), .ram_rdata(ram_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One register-bus cycle; outputs sampled on the following falling edge.
  task automatic bus(input logic w, input logic [REG_AW-1:0] a, input logic [31:0] d,
                     input logic [3:0] be, input logic [NUM_CH-1:0] hs,
                     output logic [31:0] rd, output logic rv, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    host_set = hs;
    @(negedge clk);
    rd = rsp_rdata; rv = rsp_valid; er = err;
    req_valid = 1'b0; req_write = 1'b0; host_set = '0;
  endtask

  task automatic rd_reg(input logic [REG_AW-1:0] a, output logic [31:0] v);
    logic rv, er;
    bus(1'b0, a, 32'h0, 4'hF, '0, v, rv, er);
  endtask

  task automatic wr_reg(input logic [REG_AW-1:0] a, input logic [31:0] d);
    logic [31:0] rd; logic rv, er;
    bus(1'b1, a, d, 4'hF, '0, rd, rv, er);
  endtask

  task automatic idle(input logic [NUM_CH-1:0] hs);
    @(negedge clk); host_set = hs;
    @(negedge clk); host_set = '0;
  endtask

  task automatic ram_op(input logic w, input logic [RAM_WAW-1:0] a, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] rd, output logic rv);
    @(negedge clk);
    ram_valid = 1'b1; ram_write = w; ram_addr = a; ram_be = be; ram_wdata = d;
    @(negedge clk);
    rd = ram_rdata; rv = ram_rvalid;
    ram_valid = 1'b0; ram_write = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    chk("R9 irq low in reset", {31'h0, irq}, 32'h0);
    rd_reg(12'h000, v); chk("R9 status reset", v, 32'h0);
    rd_reg(12'h004, v); chk("R9 control reset", v, 32'h0);
    rd_reg(12'h008, v); chk("R9 command reset", v, 32'h0);
  endtask

  task automatic t_rsp_timing();
    logic [31:0] rd; logic rv, er;
    bus(1'b0, 12'h004, 32'h0, 4'hF, '0, rd, rv, er);
    chk("R1 rsp_valid after read", {31'h0, rv}, 32'h1);
    bus(1'b1, 12'h008, 32'h0, 4'hF, '0, rd, rv, er);
    chk("R1 no rsp_valid after write", {31'h0, rv}, 32'h0);
  endtask

  task automatic t_control();
    logic [31:0] v;
    wr_reg(12'h004, 32'hA5A5_00F0);
    rd_reg(12'h004, v); chk("R3 control replace", v, 32'hA5A5_00F0);
    wr_reg(12'h004, 32'h0000_0F00);
    rd_reg(12'h004, v); chk("R3 control replace again", v, 32'h0000_0F00);
  endtask

  task automatic t_command();
    logic [31:0] v;
    wr_reg(12'h008, 32'h0000_0011);
    wr_reg(12'h008, 32'h8000_0100);
    rd_reg(12'h008, v); chk("R4 command OR", v, 32'h8000_0111);
    wr_reg(12'h008, 32'h0);
    rd_reg(12'h008, v); chk("R4 command not cleared", v, 32'h8000_0111);
  endtask

  task automatic t_status();
    logic [31:0] v;
    idle(8'h0F);
    rd_reg(12'h000, v); chk("R6 host set", v, 32'h0000_000F);
    wr_reg(12'h000, 32'hFFFF_FF05);
    rd_reg(12'h000, v); chk("R2 W1C", v, 32'h0000_000A);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr_reg(12'h004, 32'h0000_01F0);
    chk("R5 irq off, no overlap", {31'h0, irq}, 32'h0);
    wr_reg(12'h004, 32'h0000_0002);
    chk("R5 irq on after enable", {31'h0, irq}, 32'h1);
    wr_reg(12'h000, 32'h0000_0002);
    chk("R5 irq off after clear", {31'h0, irq}, 32'h0);
    wr_reg(12'h004, 32'hFFFF_FF00);
    idle(8'h00);
    chk("R5 bits above mask ignored", {31'h0, irq}, 32'h0);
    rd_reg(12'h000, v); chk("R5 status kept", v, 32'h0000_0008);
  endtask

  task automatic t_race();
    logic [31:0] rd, v; logic rv, er;
    bus(1'b1, 12'h000, 32'h0000_000C, 4'hF, 8'h04, rd, rv, er);
    rd_reg(12'h000, v); chk("R6 set wins over clear", v, 32'h0000_0004);
  endtask

  task automatic t_unmapped();
    logic [31:0] rd, v; logic rv, er;
    bus(1'b0, 12'h00C, 32'h0, 4'hF, '0, rd, rv, er);
    chk("R7 unmapped read zero", rd, 32'h0);
    chk("R7 err pulse on read", {31'h0, er}, 32'h1);
    idle(8'h00);
    chk("R7 err single cycle", {31'h0, err}, 32'h0);
    bus(1'b1, 12'hFFC, 32'hFFFF_FFFF, 4'hF, '0, rd, rv, er);
    chk("R7 err pulse on write", {31'h0, er}, 32'h1);
    bus(1'b1, 12'h006, 32'hFFFF_FFFF, 4'hF, '0, rd, rv, er);
    rd_reg(12'h004, v); chk("R7 control untouched", v, 32'hFFFF_FF00);
    rd_reg(12'h000, v); chk("R7 status untouched", v, 32'h0000_0004);
    rd_reg(12'h008, v); chk("R7 command untouched", v, 32'h8000_0111);
  endtask

  task automatic t_bad_be();
    logic [31:0] rd, v; logic rv, er;
    bus(1'b1, 12'h004, 32'h0, 4'h3, '0, rd, rv, er);
    chk("R8 err on partial write", {31'h0, er}, 32'h1);
    rd_reg(12'h004, v); chk("R8 control unchanged", v, 32'hFFFF_FF00);
    bus(1'b0, 12'h008, 32'h0, 4'h1, '0, rd, rv, er);
    chk("R8 partial read zero", rd, 32'h0);
    chk("R8 err on partial read", {31'h0, er}, 32'h1);
    bus(1'b1, 12'h000, 32'hFF, 4'hE, '0, rd, rv, er);
    rd_reg(12'h000, v); chk("R8 status unchanged", v, 32'h0000_0004);
  endtask

  task automatic t_ram();
    logic [31:0] rd; logic rv;
    ram_op(1'b0, 6'd5, 4'hF, 32'h0, rd, rv);
    chk("R10 unwritten word zero", rd, 32'h0);
    chk("R10 rvalid", {31'h0, rv}, 32'h1);
    ram_op(1'b1, 6'd5, 4'h3, 32'h1234_ABCD, rd, rv);
    chk("R10 no rvalid on write", {31'h0, rv}, 32'h0);
    ram_op(1'b0, 6'd5, 4'hF, 32'h0, rd, rv);
    chk("R10 partial first write", rd, 32'h0000_ABCD);
    ram_op(1'b1, 6'd5, 4'hC, 32'hFFFF_0000, rd, rv);
    ram_op(1'b0, 6'd5, 4'hF, 32'h0, rd, rv);
    chk("R10 byte merge", rd, 32'hFFFF_ABCD);
    ram_op(1'b1, 6'd63, 4'hF, 32'hDEAD_BEEF, rd, rv);
    ram_op(1'b0, 6'd63, 4'hF, 32'h0, rd, rv);
    chk("R10 last word", rd, 32'hDEAD_BEEF);
  endtask

  task automatic t_reset_again();
    logic [31:0] rd, v; logic rv;
    do_reset();
    chk("R9 irq low after reset", {31'h0, irq}, 32'h0);
    rd_reg(12'h008, v); chk("R9 command cleared", v, 32'h0);
    rd_reg(12'h000, v); chk("R9 status cleared", v, 32'h0);
    ram_op(1'b0, 6'd5, 4'hF, 32'h0, rd, rv);
    chk("R10 word zero after reset", rd, 32'h0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_rsp_timing();
    t_control();
    t_command();
    t_status();
    t_irq();
    t_race();
    t_unmapped();
    t_bad_be();
    t_ram();
    t_reset_again();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule